// File: doc/BRIEF.md
# Clock Selection Register with Safety Interlocks

This block holds the byte-wide control word that picks the clock sources of a chip. It chooses whether the system clock prescaler is fed by the main crystal clock or by the PLL. It controls PLL power-down and picks the source of the slow clock. It also gates two auxiliary clocks and shows a power-on status flag when the word is read back. The clock multiplexers, the prescaler and the PLL lie outside the block. They consume the select and enable outputs.

Software writes the whole byte in one bus cycle, and the bus can read it back at any time. Some writes would leave the system without a clock: running from a PLL that is off or still settling, or powering down the PLL while it drives the system. The block drops the offending field of such a write and accepts every other field of the same write. It raises no error.

Top module: `clk_ctrl_interlock`

## Requirements
- R1: During and right after a synchronous active-low reset, the register reads slow select 0, fast select 1, PLL power-down 1 and both auxiliary enables 0. Read data is therefore 0x06, with bit 5 added when the power-on flag is high.
- R2: Read data layout: bit0 slow select, bit1 fast select, bit2 PLL power-down, bit3 aux 1 enable, bit4 aux 2 enable, bit5 the live power-on flag input. Bits 7:6 always read 0. Each select and enable output equals its read-back bit.
- R3: Slow select and both auxiliary enables take the written value on every write. For slow select, 1 picks the 32.768 kHz oscillator and 0 picks the prescaled main clock.
- R4: Writing fast select to 1 always takes effect. For fast select, 1 means the main clock drives the system prescaler and 0 means the PLL does.
- R5: A write that would clear fast select is ignored for that bit while the stored PLL power-down bit is 1.
- R6: A write that would clear fast select is ignored for that bit while the PLL-stable input is low.
- R7: A write that sets PLL power-down takes effect only if fast select is 1 after the same write. A single write that sets fast select and power-down together therefore succeeds for both.
- R8: Writing PLL power-down to 0 always takes effect.
- R9: Without a write enable the register holds its value whatever the write data. Writes to bits 7:5 change nothing.
- R10: Fast select 0 and PLL power-down 1 are never stored at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Byte to write |
| pll_stable | input | 1 | High when the PLL output has settled |
| por_flag | input | 1 | Power-on status flag shown in bit 5 |
| rd_data | output | 8 | Current register value |
| slow_src_osc | output | 1 | 1: slow clock from the 32.768 kHz oscillator |
| sys_src_main | output | 1 | 1: system prescaler from the main clock; 0: from the PLL |
| pll_off | output | 1 | PLL power-down request |
| aux_en | output | 2 | Auxiliary clock enables, index 0 is aux 1 |

## Verification
The hardest case to reach from the ports is a write arriving while the PLL is already selected and running: fast select 0 and power-down 0. That state needs two earlier accepted writes, the second made while the PLL reports stable. The bench drives each starting state (main clock with PLL on, main clock with PLL off, PLL in use) with a short write sequence. From each state it applies all 256 write bytes under both PLL-stable levels and both power-on flag levels. After every write it checks each field against an arithmetic model, then holds the write enable low with inverted data to confirm nothing moves.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    // Field positions; the read-back layout depends on them
    localparam int SLOW_BIT = 0;
    localparam int FAST_BIT = 1;
    localparam int PDN_BIT  = 2;
    localparam int AUX_BASE = 3;
endpackage

// File: rtl/clkctl_next.sv
// clkctl_next: combinational next-value logic for the control word.
// Applies the write data field by field and drops the fast-select clear
// or the power-down set when an interlock forbids it.
// Assumes cur never holds the PLL-selected-and-off combination.
module clkctl_next
    import clkctl_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int N_AUX = 2
) (
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] wd,
    input  logic             pll_stable,
    output logic [REG_W-1:0] nxt
);
    localparam int WR_BITS = AUX_BASE + N_AUX;
    localparam logic [REG_W-1:0] WMASK = REG_W'((1 << WR_BITS) - 1);

    // Merge the write, then veto the unsafe field changes
    always_comb begin
        nxt = wd & WMASK;
        if (!wd[FAST_BIT] && cur[FAST_BIT] && (cur[PDN_BIT] || !pll_stable))
            nxt[FAST_BIT] = 1'b1;
        if (wd[PDN_BIT] && !cur[PDN_BIT] && !nxt[FAST_BIT])
            nxt[PDN_BIT] = 1'b0;
    end
endmodule

// File: rtl/clkctl_state.sv
// clkctl_state: storage of the writable fields with synchronous
// active-low reset. Assumes nxt is already interlock-checked.
module clkctl_state
    import clkctl_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] nxt,
    output logic [REG_W-1:0] q
);
    localparam logic [REG_W-1:0] RST_VAL =
        REG_W'((1 << FAST_BIT) | (1 << PDN_BIT));

    // Load on write, return to the safe default on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RST_VAL;
        else if (wr_en) q <= nxt;
    end

    // R10: PLL never selected while powered down
    assert_no_pll_off_in_use_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!q[FAST_BIT] && q[PDN_BIT]));

    // R9: idle cycles leave the register untouched
    assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(q));
endmodule

// File: rtl/clk_ctrl_interlock.sv
// clk_ctrl_interlock: byte-wide clock-selection register with interlocks.
// Read data is the stored word with the live power-on flag merged in.
// Assumes a single clock domain for bus, pll_stable and por_flag.
module clk_ctrl_interlock
    import clkctl_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int N_AUX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pll_stable,
    input  logic             por_flag,
    output logic [REG_W-1:0] rd_data,
    output logic             slow_src_osc,
    output logic             sys_src_main,
    output logic             pll_off,
    output logic [N_AUX-1:0] aux_en
);
    localparam int POR_BIT = AUX_BASE + N_AUX;

    logic [REG_W-1:0] cur;
    logic [REG_W-1:0] nxt;

    clkctl_next #(.REG_W(REG_W), .N_AUX(N_AUX)) u_next (
        .cur(cur), .wd(wr_data), .pll_stable(pll_stable), .nxt(nxt)
    );

    clkctl_state #(.REG_W(REG_W)) u_state (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .nxt(nxt), .q(cur)
    );

    // Read-back: stored fields plus the live status flag
    always_comb begin
        rd_data = cur;
        rd_data[POR_BIT] = por_flag;
    end

    // Fixed selects and power-down decoded from their field positions
    assign slow_src_osc = cur[SLOW_BIT];
    assign sys_src_main = cur[FAST_BIT];
    assign pll_off      = cur[PDN_BIT];

    // One enable per auxiliary clock
    for (genvar i = 0; i < N_AUX; i++) begin : g_aux
        assign aux_en[i] = cur[AUX_BASE + i];
    end

    // R5/R6: a switch to the PLL needs it powered up and settled
    assert_pll_switch_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_src_main) |-> ($past(pll_stable) && !$past(pll_off) && $past(wr_en)));

    // R7: power-down appears only with the main clock selected
    assert_pdn_needs_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_off) |-> (sys_src_main && $past(wr_en)));

    // R3: first auxiliary enable follows the written bit
    assert_aux_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (aux_en[0] == $past(wr_data[AUX_BASE])));
endmodule

// File: tb/tb_clk_ctrl_interlock.sv
module tb_clk_ctrl_interlock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pll_stable = 1'b0;
    logic       por_flag = 1'b0;
    logic [7:0] rd_data;
    logic       slow_src_osc, sys_src_main, pll_off;
    logic [1:0] aux_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clk_ctrl_interlock dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pll_stable(pll_stable), .por_flag(por_flag), .rd_data(rd_data),
        .slow_src_osc(slow_src_osc), .sys_src_main(sys_src_main),
        .pll_off(pll_off), .aux_en(aux_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Compare every port-visible field against an expected stored word
    task automatic chk_all(input logic [7:0] e, input string fast_req, input string pdn_req);
        chk("R2 reserved", int'(rd_data[7:6]), 0);
        chk("R2 por", int'(rd_data[5]), int'(por_flag));
        chk("R3 slow/aux", int'({rd_data[4:3], rd_data[0]}), int'({e[4:3], e[0]}));
        chk(fast_req, int'(rd_data[1]), int'(e[1]));
        chk(pdn_req, int'(rd_data[2]), int'(e[2]));
        chk("R2 ports", int'({aux_en, pll_off, sys_src_main, slow_src_osc}), int'(rd_data[4:0]));
        chk("R10 safe", int'(!rd_data[1] && rd_data[2]), 0);
    endtask

    initial begin
        // R1: reset value with both flag levels
        por_flag = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset in", int'(rd_data), 'h26);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset out", int'(rd_data), 'h26);
        por_flag = 1'b0;
        #1;
        chk("R1 por0", int'(rd_data), 'h06);
        chk("R1 ports", int'({aux_en, pll_off, sys_src_main, slow_src_osc}), 'h06);

        for (int st = 0; st < 3; st++) begin
            for (int d = 0; d < 256; d++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    logic [7:0] base, cur, exp;
                    logic f, p, nf, np;
                    string fr, pr;
                    base = 8'((d * 5 + sp * 3 + st) & 8'h19);
                    // Bring the register to the chosen start state
                    pll_stable = 1'b1;
                    wr(base | 8'h02);
                    if (st == 1) wr(base | 8'h06);
                    if (st == 2) wr(base);
                    f = (st != 2);
                    p = (st == 1);
                    cur = base | {5'b0, p, f, 1'b0};
                    chk("R4 setup", int'(rd_data[2:0]), int'({p, f, base[0]}));
                    pll_stable = sp[0];
                    por_flag = sp[1];
                    wr(8'(d));
                    // Expected value from the rules
                    nf = d[1] ? 1'b1 : ((p || !pll_stable) ? f : 1'b0);
                    np = d[2] ? (nf ? 1'b1 : p) : 1'b0;
                    exp = {3'b0, d[4], d[3], np, nf, d[0]};
                    if (!d[1] && f && p) fr = "R5 fast blocked by pdn";
                    else if (!d[1] && f && !pll_stable) fr = "R6 fast blocked by unstable";
                    else fr = "R4 fast";
                    pr = d[2] ? "R7 pdn set" : "R8 pdn clear";
                    chk_all(exp, fr, pr);
                    // R9: idle cycle with inverted data must change nothing
                    wr_data = ~8'(d);
                    pll_stable = ~pll_stable;
                    @(negedge clk);
                    chk("R9 hold", int'(rd_data[4:0]), int'(exp[4:0]));
                    if (cur == 8'hFF) chk("R9 unreachable", 0, 1);
                end
            end
        end

        // R9: writes to bits 7:5 alone leave the stored word as it is
        wr(8'hE2);
        wr(8'hE2 | 8'h00);
        chk("R9 upper bits", int'(rd_data[4:0]), 'h02);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule